// File: doc/BRIEF.md
# Dual-Level Beam Permit Matrix

This block is the fast hardware path of a magnet-powering interlock controller. It watches up to 96 per-circuit failure lines and four global fault lines: redundant UPS failure, emergency-stop activation, loss of the cryogenics hold signal, and a cryogenics link error. It also watches an operator dump command. From these inputs it drives two beam permits towards the beam interlock side. The unmaskable permit drops for essential-class conditions. The maskable permit drops for those conditions and also for auxiliary circuit failures.

Each circuit carries a three-bit classification word held in a small register file. The word is written through a plain address/data port. A dropped permit stays dropped until a rearm pulse arrives at a time when no cause is present. A live matrix status flag reports whether an essential-class condition is active. A separate subsector-off request follows circuits that carry the subsector flag.

Top module: `perm_matrix`

## Requirements
- R1: While reset is asserted both permits, the matrix status flag and the subsector request are 0. After reset the permits stay 0 until the first rearm pulse.
- R2: A failing circuit whose word has bit 0 (essential) set drops both permits and drives the matrix status flag to 0. This holds whatever bit 1 is.
- R3: A failing circuit whose word has bit 1 (auxiliary) set and bit 0 clear drops only the maskable permit. The unmaskable permit and the matrix status flag stay 1.
- R4: Each of the four global fault inputs drops both permits and clears the matrix status flag, whatever the circuit classification.
- R5: The operator dump input drops both permits and clears the matrix status flag.
- R6: A dropped permit stays 0 after its cause goes away. A rearm pulse restores it only when no cause for that permit is present. A rearm pulse while a cause is present has no effect.
- R7: A configuration write is accepted only while both permits are 0. A write made while either permit is 1 leaves the stored word unchanged.
- R8: A circuit whose word has bits 0 and 1 both clear has no effect on either permit.
- R9: The subsector request is 1, without latching, while any failing circuit has word bit 2 set. That bit has no effect on the permits.
- R10: Whenever the unmaskable permit is 0, the maskable permit is also 0.
- R11: A cause asserted on an input is seen at the outputs after the third rising clock edge: two synchroniser stages plus one output register. Before that edge the outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| circ_fail_i | input | 96 | Per-circuit failure lines, 1 = failure, asynchronous |
| ups_fault_i | input | 1 | Redundant UPS fault, 1 = fault, asynchronous |
| estop_i | input | 1 | Emergency stop active, asynchronous |
| cryo_hold_lost_i | input | 1 | Cryogenics hold signal lost, asynchronous |
| cryo_link_err_i | input | 1 | Cryogenics communication error, asynchronous |
| op_dump_i | input | 1 | Operator dump command, asynchronous level |
| rearm_i | input | 1 | Synchronous rearm pulse |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Circuit index for the write |
| cfg_wdata_i | input | 3 | Word: bit 0 essential, bit 1 auxiliary, bit 2 subsector-off |
| perm_unmask_o | output | 1 | Unmaskable beam permit, 1 = beam allowed |
| perm_mask_o | output | 1 | Maskable beam permit, 1 = beam allowed |
| matrix_ok_o | output | 1 | 0 while an essential-class condition is active |
| subsector_off_o | output | 1 | Subsector power-off request |

## Verification
The assertions assume that the rearm and configuration inputs are synchronous to the block clock. They also assume that a fault input is held long enough to pass the synchroniser, so that every cause appears as a stable level for at least one cycle after the second stage. The stimulus changes every input a fixed 2 ns after a rising edge. It holds each fault for at least three edges and waits three edges after releasing a fault before any rearm pulse. This keeps the latching and lock properties inside their intended preconditions.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int CFG_W = 3;

  typedef struct packed {
    logic ss_off;
    logic aux;
    logic ess;
  } circ_cfg_t;

  localparam int GLOB_N = 4;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/pm_cfg_store.sv
module pm_cfg_store
  import pm_pkg::*;
#(
  parameter int N  = 96,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  circ_cfg_t     wdata_i,
  input  logic          unlock_i,
  output logic [N-1:0]  ess_o,
  output logic [N-1:0]  aux_o,
  output logic [N-1:0]  ss_o
);
  circ_cfg_t    cfg_q   [N];
  circ_cfg_t    cfg_nxt [N];
  logic [N-1:0] wr_hit;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_ent
      assign wr_hit[i] = we_i & unlock_i & (addr_i == AW'(i));

      always_comb begin
        cfg_nxt[i] = cfg_q[i];
        if (wr_hit[i]) cfg_nxt[i] = wdata_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q[i] <= '0;
        else if (wr_hit[i]) cfg_q[i] <= cfg_nxt[i];
      end

      assign ess_o[i] = cfg_q[i].ess;
      assign aux_o[i] = cfg_q[i].aux;
      assign ss_o[i]  = cfg_q[i].ss_off;
    end
  endgenerate

  // R7
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !unlock_i) |=> ($stable(ess_o) && $stable(aux_o) && $stable(ss_o)));
endmodule

// File: rtl/pm_classify.sv
module pm_classify #(
  parameter int N      = 96,
  parameter int GLOB_N = 4
) (
  input  logic [N-1:0]      fail_i,
  input  logic [N-1:0]      ess_i,
  input  logic [N-1:0]      aux_i,
  input  logic [N-1:0]      ss_i,
  input  logic [GLOB_N-1:0] glob_i,
  input  logic              op_dump_i,
  output logic              cause_ess_o,
  output logic              cause_mask_o,
  output logic              ss_hit_o
);
  logic [N-1:0] ess_fail;
  logic [N-1:0] aux_only_fail;

  always_comb begin
    ess_fail      = fail_i & ess_i;
    aux_only_fail = fail_i & aux_i & ~ess_i;
    cause_ess_o   = (|ess_fail) | (|glob_i) | op_dump_i;
    cause_mask_o  = cause_ess_o | (|aux_only_fail);
    ss_hit_o      = |(fail_i & ss_i);
  end
endmodule

// File: rtl/pm_latch.sv
module pm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cause_i,
  input  logic rearm_i,
  output logic permit_o
);
  logic drop_q;
  logic drop_nxt;

  always_comb begin
    drop_nxt = drop_q;
    if (cause_i)      drop_nxt = 1'b1;
    else if (rearm_i) drop_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= 1'b1;
    else        drop_q <= drop_nxt;
  end

  assign permit_o = ~drop_q;

  // R6
  cause_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_i |=> !permit_o);

  // R6
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!permit_o && !rearm_i) |=> !permit_o);
endmodule

// File: rtl/perm_matrix.sv
module perm_matrix
  import pm_pkg::*;
#(
  parameter int N        = 96,
  parameter int SYNC_STG = 2,
  parameter int AW       = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  circ_fail_i,
  input  logic          ups_fault_i,
  input  logic          estop_i,
  input  logic          cryo_hold_lost_i,
  input  logic          cryo_link_err_i,
  input  logic          op_dump_i,
  input  logic          rearm_i,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [2:0]    cfg_wdata_i,
  output logic          perm_unmask_o,
  output logic          perm_mask_o,
  output logic          matrix_ok_o,
  output logic          subsector_off_o
);
  localparam int SW = N + GLOB_N + 1;

  logic [SW-1:0]     raw_in;
  logic [SW-1:0]     syn_in;
  logic [N-1:0]      fail_s;
  logic [GLOB_N-1:0] glob_s;
  logic              op_s;
  logic [N-1:0]      ess_m, aux_m, ss_m;
  logic              cause_ess, cause_mask, ss_hit;
  logic [1:0]        lvl_cause, lvl_perm;
  logic              unlock;
  logic              ok_q, ok_nxt, ss_q, ss_nxt;
  circ_cfg_t         wword;

  assign raw_in = {op_dump_i, cryo_link_err_i, cryo_hold_lost_i, estop_i, ups_fault_i, circ_fail_i};

  pm_sync #(.W(SW), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn_in)
  );

  assign fail_s = syn_in[N-1:0];
  assign glob_s = syn_in[N +: GLOB_N];
  assign op_s   = syn_in[SW-1];

  assign unlock = ~perm_unmask_o & ~perm_mask_o;
  assign wword  = circ_cfg_t'(cfg_wdata_i);

  pm_cfg_store #(.N(N), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(wword), .unlock_i(unlock),
    .ess_o(ess_m), .aux_o(aux_m), .ss_o(ss_m)
  );

  pm_classify #(.N(N), .GLOB_N(GLOB_N)) u_cls (
    .fail_i(fail_s), .ess_i(ess_m), .aux_i(aux_m), .ss_i(ss_m),
    .glob_i(glob_s), .op_dump_i(op_s),
    .cause_ess_o(cause_ess), .cause_mask_o(cause_mask), .ss_hit_o(ss_hit)
  );

  assign lvl_cause = {cause_mask, cause_ess};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_lvl
      pm_latch u_lat (
        .clk(clk), .rst_n(rst_n), .cause_i(lvl_cause[g]),
        .rearm_i(rearm_i), .permit_o(lvl_perm[g])
      );
    end
  endgenerate

  assign perm_unmask_o = lvl_perm[0];
  assign perm_mask_o   = lvl_perm[1];

  always_comb begin
    ok_nxt = ~cause_ess;
    ss_nxt = ss_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0;
      ss_q <= 1'b0;
    end else begin
      ok_q <= ok_nxt;
      ss_q <= ss_nxt;
    end
  end

  assign matrix_ok_o     = ok_q;
  assign subsector_off_o = ss_q;

  // R10
  redundancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perm_unmask_o |-> !perm_mask_o);

  // R2
  status_ess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_ess |=> !matrix_ok_o);

  // R9
  subsector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_hit |=> subsector_off_o);

  // R3
  aux_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_mask && !cause_ess) |=> (!perm_mask_o && matrix_ok_o));
endmodule

// File: tb/perm_matrix_test.sv
`timescale 1ns/1ps
module perm_matrix_test;
  localparam int N  = 96;
  localparam int AW = 7;

  logic          clk, rst_n;
  logic [N-1:0]  circ_fail;
  logic          ups, estop, cryo_hold, cryo_link, op_dump, rearm;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [2:0]    cfg_wdata;
  logic          perm_u, perm_m, mok, ssoff;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  perm_matrix uut (
    .clk(clk), .rst_n(rst_n), .circ_fail_i(circ_fail),
    .ups_fault_i(ups), .estop_i(estop), .cryo_hold_lost_i(cryo_hold),
    .cryo_link_err_i(cryo_link), .op_dump_i(op_dump), .rearm_i(rearm),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .perm_unmask_o(perm_u), .perm_mask_o(perm_m),
    .matrix_ok_o(mok), .subsector_off_o(ssoff)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic outs(string req, logic u, logic m, logic ok);
    chk(req, "perm_unmask", perm_u, u);
    chk(req, "perm_mask", perm_m, m);
    chk(req, "matrix_ok", mok, ok);
    if (!perm_u) chk("R10", "mask follows unmask", perm_m, 1'b0);
  endtask

  task automatic wr_cfg(int a, logic [2:0] v);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = v;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic rearm_pulse();
    rearm = 1'b1;
    step(1);
    rearm = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; circ_fail = '0; ups = 0; estop = 0; cryo_hold = 0;
    cryo_link = 0; op_dump = 0; rearm = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    step(3);
    outs("R1", 1'b0, 1'b0, 1'b0);
    chk("R1", "subsector_off in reset", ssoff, 1'b0);
    rst_n = 1'b1;
    step(4);
    chk("R1", "unmask held after reset", perm_u, 1'b0);
    chk("R1", "mask held after reset", perm_m, 1'b0);
  endtask

  task automatic t_setup();
    wr_cfg(5, 3'b001);
    wr_cfg(10, 3'b010);
    wr_cfg(20, 3'b011);
    wr_cfg(40, 3'b100);
    wr_cfg(95, 3'b001);
    rearm_pulse();
    outs("R6", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_essential();
    circ_fail[5] = 1'b1;
    step(2);
    chk("R11", "unmask before third edge", perm_u, 1'b1);
    step(1);
    outs("R2", 1'b0, 1'b0, 1'b0);
    circ_fail[5] = 1'b0;
    step(4);
    chk("R6", "unmask latched after release", perm_u, 1'b0);
    chk("R6", "mask latched after release", perm_m, 1'b0);
    chk("R2", "status recovers live", mok, 1'b1);
    rearm_pulse();
    outs("R6", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_rearm_blocked();
    circ_fail[95] = 1'b1;
    step(3);
    outs("R2", 1'b0, 1'b0, 1'b0);
    rearm_pulse();
    outs("R6", 1'b0, 1'b0, 1'b0);
    circ_fail[95] = 1'b0;
    step(3);
    rearm_pulse();
    outs("R6", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_aux_and_lock();
    circ_fail[10] = 1'b1;
    step(3);
    outs("R3", 1'b1, 1'b0, 1'b1);
    wr_cfg(30, 3'b001);
    circ_fail[10] = 1'b0;
    step(3);
    rearm_pulse();
    outs("R3", 1'b1, 1'b1, 1'b1);
    circ_fail[30] = 1'b1;
    step(4);
    chk("R7", "locked write ignored, unmask", perm_u, 1'b1);
    chk("R8", "unclassified circuit, mask", perm_m, 1'b1);
    circ_fail[30] = 1'b0;
    step(3);
  endtask

  task automatic t_both_flags();
    circ_fail[20] = 1'b1;
    step(3);
    outs("R2", 1'b0, 1'b0, 1'b0);
    circ_fail[20] = 1'b0;
    step(3);
    rearm_pulse();
    outs("R2", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_globals();
    for (int k = 0; k < 5; k++) begin
      ups = (k == 0); estop = (k == 1); cryo_hold = (k == 2);
      cryo_link = (k == 3); op_dump = (k == 4);
      step(3);
      outs((k == 4) ? "R5" : "R4", 1'b0, 1'b0, 1'b0);
      ups = 0; estop = 0; cryo_hold = 0; cryo_link = 0; op_dump = 0;
      step(3);
      rearm_pulse();
      outs((k == 4) ? "R5" : "R4", 1'b1, 1'b1, 1'b1);
    end
  endtask

  task automatic t_subsector();
    circ_fail[40] = 1'b1;
    step(3);
    chk("R9", "subsector request set", ssoff, 1'b1);
    outs("R9", 1'b1, 1'b1, 1'b1);
    circ_fail[40] = 1'b0;
    step(3);
    chk("R9", "subsector request clears", ssoff, 1'b0);
  endtask

  task automatic t_cfg_unlocked();
    op_dump = 1'b1;
    step(3);
    op_dump = 1'b0;
    step(3);
    wr_cfg(30, 3'b001);
    rearm_pulse();
    outs("R7", 1'b1, 1'b1, 1'b1);
    circ_fail[30] = 1'b1;
    step(3);
    outs("R7", 1'b0, 1'b0, 1'b0);
    circ_fail[30] = 1'b0;
    step(3);
    rearm_pulse();
  endtask

  initial begin
    t_reset();
    t_setup();
    t_essential();
    t_rearm_blocked();
    t_aux_and_lock();
    t_both_flags();
    t_globals();
    t_subsector();
    t_cfg_unlocked();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL all: watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule